// File: doc/BRIEF.md
# Key-Commanded Independent Watchdog

This block is a free-running supervisory timer. Software drives it through a simple write bus with three targets: a 16-bit command (key) port, a 3-bit divider-select field and a 12-bit reload value. Configuration is guarded. The divider and reload fields accept writes only after a dedicated unlock key has been written, and any other key value locks them again.

A start key sets the timer running. After that, no key value and no other input stops it; only power-on reset does. While it runs, each active cycle of the slow `tick` enable advances a power-of-two prescaler. Every prescaler wrap decrements a 12-bit down-counter. Software keeps the system alive by writing the service key, which refills the counter from the reload value.

If the counter is allowed to run out, the block pulses `rst_req` for one clock toward the system reset controller. It also refills the counter and sets a sticky cause flag. The flag survives the resulting system reset and is cleared only through `flag_clr` or power-on reset.

Top module: `keywdog`

## Requirements
- R1: After power-on reset (`rst_n` low):
  - `running`, `unlocked`, `cause_flag` and `rst_req` are 0.
  - `count` is 0xFFF.
  - The divider select is 0 and the reload value is 0xFFF.
- R2: The write bus selects its target with `wr_sel`: 0 is the key port, 1 is the divider select, 2 is the reload value, and 3 is ignored.
  - A key write of 0x5555 sets `unlocked`.
  - A key write of any other value clears `unlocked`.
  - Divider and reload writes made while `unlocked` is 0 have no effect.
- R3: The prescaler divides `tick` by 4·2^P, where P is the divider select. A written value above 6 is stored as 6, so the largest divide is 256.
- R4: A key write of 0xCCCC sets `running`, loads `count` from the reload value and restarts the prescaler phase.
- R5: Expiry timing and behaviour:
  - With `tick` high every cycle and reload value V, the first `rst_req` pulse comes in the clock cycle (V+1)·4·2^P edges after the start edge.
  - The pulse is one cycle wide.
  - The counter refills on expiry, so pulses repeat with the same period.
- R6: A key write of 0xAAAA loads `count` from the reload value and restarts the prescaler phase. If it lands on the same edge as an expiry, the expiry is cancelled.
- R7: Once `running` is 1, it stays 1 until power-on reset, whatever keys are written.
- R8: `cause_flag` is set on the edge that raises `rst_req` and stays set until `flag_clr` is high on an edge. If an expiry and `flag_clr` fall on the same edge, the set wins.
- R9: While `tick` is low, neither the prescaler nor `count` advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Slow-time enable; one prescaler step per high cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 key, 1 divider select, 2 reload, 3 none |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clears the sticky cause flag |
| running | output | 1 | Watchdog started |
| unlocked | output | 1 | Divider and reload writes are accepted |
| cause_flag | output | 1 | Sticky: a watchdog expiry occurred |
| count | output | 12 | Current down-counter value |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench goes after the following corner cases, each with the symptom a faulty design would show:
- **Exact expiry cycle.** It times expiry to the exact cycle for several divider and reload settings, including a reload of 0 and a divider select of 7. An off-by-one in the prescaler compare shifts every pulse, and a missing saturation doubles the longest period.
- **Locked writes.** It writes the reload and divider values while locked and after a relocking key. A design that lets those writes through would refill the counter with the wrong value at the next expiry.
- **Stop attempts.** It writes non-command keys after start to try to stop the timer. A design that honours them would drop `running` and miss the repeating pulses.
- **Clear racing expiry.** It holds `flag_clr` across an expiry edge. A design that gives the clear priority would leave the flag low even though a reset request was issued.
- **Service.** It shifts the pulse by servicing mid-count; a service that failed to restart the prescaler phase would fire a few cycles early.

// File: rtl/keywdog.sv
module keywdog #(
  parameter int KEY_W    = 16,
  parameter int PRE_W    = 3,
  parameter int RLD_W    = 12,
  parameter int PRE_MAX  = 6,
  parameter int BASE_LOG = 2,
  parameter logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_SERVICE = 16'hAAAA,
  parameter logic [KEY_W-1:0] KEY_START   = 16'hCCCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic             running,
  output logic             unlocked,
  output logic             cause_flag,
  output logic [RLD_W-1:0] count,
  output logic             rst_req
);

  localparam int DIV_W = BASE_LOG + PRE_MAX;
  localparam logic [1:0] SEL_KEY = 2'd0;
  localparam logic [1:0] SEL_PRE = 2'd1;
  localparam logic [1:0] SEL_RLD = 2'd2;

  logic [PRE_W-1:0] pre_q, pre_in;
  logic [RLD_W-1:0] rld_q, cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   div_span;
  logic             unl_q, run_q, flag_q, req_q;
  logic             key_wr, do_unlock, do_service, do_start, reload;
  logic             pre_wr, rld_wr, div_last, ptick, expire;

  assign key_wr     = wr_en && (wr_sel == SEL_KEY);
  assign do_unlock  = key_wr && (wr_data == KEY_UNLOCK);
  assign do_service = key_wr && (wr_data == KEY_SERVICE);
  assign do_start   = key_wr && (wr_data == KEY_START);
  assign reload     = do_service || do_start;
  assign pre_wr     = wr_en && (wr_sel == SEL_PRE) && unl_q;
  assign rld_wr     = wr_en && (wr_sel == SEL_RLD) && unl_q;

  assign pre_in   = (wr_data[PRE_W-1:0] > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : wr_data[PRE_W-1:0];
  assign div_span = (DIV_W+1)'(1) << (BASE_LOG + int'(pre_q));
  assign div_last = ({1'b0, div_q} == (div_span - 1'b1));
  assign ptick    = run_q && tick && div_last;
  assign expire   = ptick && (cnt_q == '0) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      pre_q <= '0;
      rld_q <= '1;
    end else begin
      if (key_wr) unl_q <= do_unlock;
      if (pre_wr) pre_q <= pre_in;
      if (rld_wr) rld_q <= wr_data[RLD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (do_start) run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (reload)         div_q <= '0;
    else if (run_q && tick)  div_q <= div_last ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '1;
    else if (reload)    cnt_q <= rld_q;
    else if (ptick)     cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q <= expire;
      if (expire)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign running    = run_q;
  assign unlocked   = unl_q;
  assign cause_flag = flag_q;
  assign count      = cnt_q;
  assign rst_req    = req_q;

  assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wr_data != KEY_UNLOCK) |=> !unl_q);

  assert_locked_rld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && wr_en && wr_sel == SEL_RLD) |=> $stable(rld_q));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  assert_no_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> flag_q);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !key_wr) |=> ($stable(cnt_q) && $stable(div_q)));

endmodule

// File: tb/keywdog_tb.sv
module keywdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic        flag_clr = 1'b0;
  logic        running, unlocked, cause_flag, rst_req;
  logic [11:0] count;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keywdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_clr(flag_clr), .running(running), .unlocked(unlocked),
    .cause_flag(cause_flag), .count(count), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic por();
    rst_n = 1'b0; tick = 1'b1; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    int e;
    if (rst_n && rst_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R5 reset request at cycle %0d expected none", cyc);
      end else begin
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R3/R5 reset request at cycle %0d expected cycle %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog timeout actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    por();
    check("R1 running", running, 0);
    check("R1 unlocked", unlocked, 0);
    check("R1 cause_flag", cause_flag, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 count", count, 12'hFFF);

    wr(2'd2, 16'd3);
    wr(2'd0, 16'hCCCC);
    c0 = cyc;
    check("R2 locked reload ignored", count, 12'hFFF);
    check("R4 running", running, 1);
    wait_until(c0 + 4);
    check("R4 first decrement", count, 12'hFFE);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 frozen count", count, 12'hFFE);
    tick = 1'b1;
    por();

    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'hCCCC);
    c0 = cyc;
    check("R4 count loaded", count, 5);
    exp_q.push_back(c0 + 24); exp_q.push_back(c0 + 48);
    exp_q.push_back(c0 + 72); exp_q.push_back(c0 + 96);
    wait_until(c0 + 30);
    check("R8 flag set", cause_flag, 1);
    check("R5 pulse ended", rst_req, 0);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R8 flag cleared", cause_flag, 0);
    wait_until(c0 + 46);
    flag_clr = 1'b1;
    wait_until(c0 + 48);
    check("R8 set wins over clear", cause_flag, 1);
    flag_clr = 1'b0;
    wait_until(c0 + 50);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'h5555);
    check("R2 unlock", unlocked, 1);
    wr(2'd0, 16'h1234);
    check("R2 relock", unlocked, 0);
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd6);
    check("R7 still running", running, 1);
    wait_until(c0 + 72);
    check("R2 reload kept after relock", count, 5);
    wait_until(c0 + 100);
    check("R7 running after stop attempts", running, 1);
    por();

    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'hCCCC);
    c0 = cyc;
    wait_until(c0 + 9);
    wr(2'd0, 16'hAAAA);
    check("R6 service reload", count, 5);
    exp_q.push_back(c0 + 34);
    wait_until(c0 + 40);
    por();

    // R3: divider select 2 -> divide by 16
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'hCCCC);
    c0 = cyc;
    exp_q.push_back(c0 + 48);
    wait_until(c0 + 55);
    por();

    // R3: divider select 7 saturates to 6 -> divide by 256, reload 0
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd7);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'hCCCC);
    c0 = cyc;
    exp_q.push_back(c0 + 256);
    wait_until(c0 + 260);
    por();

    check("R5 all expected pulses seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule